// File: doc/BRIEF.md
# Data memory access steering decoder

This block sits between an 8051-style core and its data memories. For each access the core presents an address, the addressing mode and a read/write flag. The block then picks exactly one target: the lower internal RAM, the upper internal RAM, the special-function-register space, the on-chip expanded RAM, or the external data bus.

The address range 80h to FFh belongs to two separate resources. Indirect accesses reach the upper RAM there, and direct accesses reach the SFR space. For external-space moves (MOVX), a control input selects what happens to the lowest 768 bytes. When that input is 0, those addresses go to a hidden on-chip RAM and the pins stay quiet. When it is 1, those addresses go out to the external bus like any other MOVX address.

All outputs are registered. A decision appears one clock after the access is presented. External read and write strobes are active low and are held for exactly that one cycle.

Top module: `ds_mem_steer`

## Requirements
- R1: A direct (acc_kind=0) or indirect (acc_kind=1) access whose low address byte is 00h–7Fh asserts sel_lo. loc_addr carries that byte with the upper byte zero.
- R2: An indirect access (acc_kind=1) to 80h–FFh asserts sel_hi and never sel_sfr.
- R3: A direct access (acc_kind=0) to 80h–FFh asserts sel_sfr and never sel_hi.
- R4: A MOVX (acc_kind=2 or 3) with xram_off=0 and a formed address of 0000h–02FFh asserts sel_xram. In that case bus_en stays 0 and bus_rd_n and bus_wr_n stay 1.
- R5: A MOVX with xram_off=1, or with a formed address of 0300h or above, asserts sel_ext and bus_en. loc_addr carries the full 16-bit address. bus_rd_n goes low for a read (acc_wr=0) and bus_wr_n goes low for a write (acc_wr=1).
- R6: A MOVX with an 8-bit pointer (acc_kind=2) forms its address as {00h, acc_addr[7:0]}. A MOVX with the 16-bit pointer (acc_kind=3) uses all of acc_addr. For direct and indirect accesses, acc_addr[15:8] has no effect.
- R7: Each valid access asserts exactly one select. When acc_vld=0, no select is asserted, bus_en is 0 and both strobes are 1.
- R8: Outputs follow the inputs of the previous clock edge. An external strobe stays low for one cycle only, unless the next access is also external. After reset, all selects are 0, bus_en is 0 and both strobes are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 direct, 1 indirect, 2 MOVX 8-bit pointer, 3 MOVX 16-bit pointer |
| acc_wr | input | 1 | 1 write, 0 read |
| acc_addr | input | 16 | Access address (8-bit modes use bits 7:0) |
| xram_off | input | 1 | 1 sends all MOVX to the external bus |
| sel_lo | output | 1 | Lower internal RAM select |
| sel_hi | output | 1 | Upper internal RAM select |
| sel_sfr | output | 1 | SFR space select |
| sel_xram | output | 1 | On-chip expanded RAM select |
| sel_ext | output | 1 | External bus select |
| loc_addr | output | 16 | Address for the selected target |
| bus_en | output | 1 | External address/data pins driven |
| bus_rd_n | output | 1 | External read strobe, active low |
| bus_wr_n | output | 1 | External write strobe, active low |

## Verification
Two functions can decide the same access: zeroing the upper byte of an 8-bit pointer, and diverting low addresses to the expanded RAM. Directed vectors cover this. They present acc_kind=2 with a nonzero acc_addr[15:8] under both xram_off values. With xram_off=0 the expanded RAM must be selected with the bus silent. With xram_off=1 the external bus must be used at address 00xxh. Random vectors mix every mode and both control values, and back-to-back external accesses are checked against idle cycles to confirm that each strobe lasts one cycle.

// File: rtl/ds_mem_steer.sv
module ds_mem_steer #(
  parameter int AW        = 16,
  parameter int NW        = 8,
  parameter int XRAM_LAST = 'h2FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_vld,
  input  logic [1:0]    acc_kind,
  input  logic          acc_wr,
  input  logic [AW-1:0] acc_addr,
  input  logic          xram_off,
  output logic          sel_lo,
  output logic          sel_hi,
  output logic          sel_sfr,
  output logic          sel_xram,
  output logic          sel_ext,
  output logic [AW-1:0] loc_addr,
  output logic          bus_en,
  output logic          bus_rd_n,
  output logic          bus_wr_n
);
  localparam logic [1:0] K_DIR = 2'd0, K_IND = 2'd1, K_MX16 = 2'd3;
  localparam logic [AW-1:0] XTOP = AW'(XRAM_LAST);

  logic          is_mx, up, in_x;
  logic [AW-1:0] eff;

  assign is_mx = acc_kind[1];
  assign eff   = (acc_kind == K_MX16) ? acc_addr
                                      : {{(AW-NW){1'b0}}, acc_addr[NW-1:0]};
  assign up    = eff[NW-1];
  assign in_x  = !xram_off && (eff <= XTOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_lo   <= 1'b0;
      sel_hi   <= 1'b0;
      sel_sfr  <= 1'b0;
      sel_xram <= 1'b0;
      sel_ext  <= 1'b0;
      loc_addr <= '0;
      bus_en   <= 1'b0;
      bus_rd_n <= 1'b1;
      bus_wr_n <= 1'b1;
    end else begin
      sel_lo   <= acc_vld && !is_mx && !up;
      sel_hi   <= acc_vld && (acc_kind == K_IND) && up;
      sel_sfr  <= acc_vld && (acc_kind == K_DIR) && up;
      sel_xram <= acc_vld && is_mx && in_x;
      sel_ext  <= acc_vld && is_mx && !in_x;
      loc_addr <= acc_vld ? eff : '0;
      bus_en   <= acc_vld && is_mx && !in_x;
      bus_rd_n <= !(acc_vld && is_mx && !in_x && !acc_wr);
      bus_wr_n <= !(acc_vld && is_mx && !in_x && acc_wr);
    end
  end
endmodule

module ds_mem_steer_chk #(parameter int AW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_vld,
  input logic [1:0]    acc_kind,
  input logic [AW-1:0] acc_addr,
  input logic          sel_lo,
  input logic          sel_hi,
  input logic          sel_sfr,
  input logic          sel_xram,
  input logic          sel_ext,
  input logic          bus_en,
  input logic          bus_rd_n,
  input logic          bus_wr_n
);
  // R7
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_lo, sel_hi, sel_sfr, sel_xram, sel_ext}));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> !(sel_lo || sel_hi || sel_sfr || sel_xram || sel_ext) && bus_rd_n && bus_wr_n);
  // R3
  direct_upper_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_kind == 2'd0 && acc_addr[7]) |=> sel_sfr && !sel_hi);
  // R2
  indirect_upper_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_kind == 2'd1 && acc_addr[7]) |=> sel_hi && !sel_sfr);
  // R4
  xram_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_xram |-> !bus_en && bus_rd_n && bus_wr_n);
  // R5
  strobe_needs_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> sel_ext && bus_en && (bus_rd_n != bus_wr_n));
endmodule

bind ds_mem_steer ds_mem_steer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_kind(acc_kind),
  .acc_addr(acc_addr), .sel_lo(sel_lo), .sel_hi(sel_hi), .sel_sfr(sel_sfr),
  .sel_xram(sel_xram), .sel_ext(sel_ext), .bus_en(bus_en),
  .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n));

// File: tb/tb_ds_mem_steer.sv
`timescale 1ns/1ps
module tb_ds_mem_steer;
  logic        clk = 0, rst_n = 0;
  logic        acc_vld = 0, acc_wr = 0, xram_off = 0;
  logic [1:0]  acc_kind = 0;
  logic [15:0] acc_addr = 0;
  logic        sel_lo, sel_hi, sel_sfr, sel_xram, sel_ext, bus_en, bus_rd_n, bus_wr_n;
  logic [15:0] loc_addr;
  int nchk = 0, nbad = 0;

  always #4 clk = ~clk;

  ds_mem_steer dut (.*);

  // expected: {sel_lo,sel_hi,sel_sfr,sel_xram,sel_ext,bus_en,rd_n,wr_n,loc_addr}
  function automatic logic [23:0] model(logic v, logic [1:0] k, logic w,
                                        logic [15:0] a, logic xo);
    logic [15:0] e;
    logic [4:0]  s;
    logic ext;
    e = (k == 2'd3) ? a : {8'h00, a[7:0]};
    s = 5'b0;
    ext = 1'b0;
    if (v) begin
      if (k == 2'd0 || k == 2'd1) begin
        if (!e[7]) s[4] = 1'b1;
        else if (k == 2'd1) s[3] = 1'b1;
        else s[2] = 1'b1;
      end else if (!xo && e <= 16'h02FF) s[1] = 1'b1;
      else begin s[0] = 1'b1; ext = 1'b1; end
    end
    return {s, ext, !(ext && !w), !(ext && w), v ? e : 16'h0000};
  endfunction

  function automatic string tag(logic v, logic [1:0] k, logic [15:0] a, logic xo);
    if (!v) return "R7";
    if (k == 2'd0) return a[7] ? "R3" : "R1";
    if (k == 2'd1) return a[7] ? "R2" : "R1";
    if (k == 2'd2) return "R6";
    if (!xo && a <= 16'h02FF) return "R4";
    return "R5";
  endfunction

  task automatic check(string t, logic [23:0] exp);
    logic [23:0] act;
    act = {sel_lo, sel_hi, sel_sfr, sel_xram, sel_ext, bus_en, bus_rd_n, bus_wr_n, loc_addr};
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic apply(logic v, logic [1:0] k, logic w, logic [15:0] a, logic xo);
    acc_vld = v; acc_kind = k; acc_wr = w; acc_addr = a; xram_off = xo;
    @(posedge clk); #1;
    check(tag(v, k, a, xo), model(v, k, w, a, xo));
  endtask

  initial begin
    #2000000;
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset", {8'b0000_0011, 16'h0000});
    rst_n = 1;
    @(posedge clk); #1;
    // R1 R2 R3 boundaries; upper byte ignored (R6)
    apply(1, 0, 0, 16'hAB7F, 0);
    apply(1, 1, 1, 16'h0000, 0);
    apply(1, 1, 0, 16'h0080, 0);
    apply(1, 0, 1, 16'h0080, 0);
    apply(1, 0, 0, 16'h12FF, 1);
    apply(1, 1, 1, 16'h55FF, 1);
    // R4 / R5 boundary at 2FF/300
    apply(1, 3, 0, 16'h02FF, 0);
    apply(1, 3, 1, 16'h0300, 0);
    apply(1, 3, 0, 16'h0000, 1);
    apply(1, 3, 1, 16'hFFFF, 0);
    // R8 strobe lasts one cycle
    apply(0, 3, 0, 16'h0300, 0);
    // R6 with diversion in the same access
    apply(1, 2, 1, 16'hFF10, 0);
    apply(1, 2, 0, 16'hFF10, 1);
    apply(1, 2, 0, 16'h03FF, 0);
    // R5 back-to-back external then idle (R8)
    apply(1, 3, 0, 16'h8000, 0);
    apply(1, 3, 1, 16'h8001, 0);
    apply(0, 0, 0, 16'h0000, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      a = $urandom;
      if ($urandom_range(3) == 0) a = {6'b0, a[9:0]};
      apply($urandom_range(7) != 0, 2'($urandom_range(3)), 1'($urandom_range(1)),
            a, 1'($urandom_range(1)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule